// File: doc/BRIEF.md
# Boot-Overlay Address Decoder

This block sits between a 16-bit-data CPU with a 24-bit byte address and the two memories behind it: a 512 KiB chip RAM and a 512 KiB boot ROM. For each access it chooses one device or none. It also reports whether that region may be read or written and hands the chosen device a 19-bit offset measured from the base of the mapping. The address space is cut into 64 regions of 256 KiB, and the top six address bits index a small table of per-region entries. Each entry holds a device code, a read-permit bit, a write-permit bit and the position of the region inside its 512 KiB device.

After reset a boot overlay places the ROM at address zero, so the processor can fetch its reset vectors from it. Boot code later clears the overlay with a control write. Low memory then becomes chip RAM, mirrored four times to fill the first 2 MiB. The top region always shows the first 256 KiB of the ROM. The table is rewritten only when the overlay value actually changes. Writes the table does not permit never reach a device and are reported on a one-cycle flag. Accesses to regions with no device read back as open bus and raise an unmapped strobe.

Top module: `boot_overlay_decoder`

## Requirements
- R1: Address bits [23:18] pick one of 64 regions of 256 KiB. For a mapped access, `dev_offset[17:0]` equals `acc_addr[17:0]`. `dev_offset[18]` is the region's position inside its two-region device: 0 for the lower region of the pair, 1 for the upper.
- R2: After reset `overlay_active` is 1 and `write_denied` is 0. Regions 0 and 1 select the ROM with read permitted and write refused, at offsets 0x00000–0x7FFFF. Regions 2 to 62 select no device.
- R3: Region 63 (0xFC0000–0xFFFFFF) always selects the ROM, read-only, in every overlay state. Its offset is the address minus 0xFC0000.
- R4: While the overlay is off, regions 0 to 7 select the RAM with read and write permitted. Each 512 KiB mirror starts at offset 0, so the offset is `acc_addr[18:0]`.
- R5: A cycle with `ovl_we` high and `ovl_val` different from `overlay_active` switches the mapping from the next cycle on. An access in that same cycle still uses the old mapping. `overlay_active` changes one cycle after the write and is otherwise held.
- R6: A cycle with `ovl_we` high and `ovl_val` equal to `overlay_active` changes neither the mapping nor `overlay_active`.
- R7: Turning the overlay back on rewrites only regions 0 and 1, back to read-only ROM. Regions 2 to 7 keep whatever they held: no device if the overlay has never been off since reset, read/write RAM otherwise.
- R8: An access to a region with no device raises `unmapped` while `acc_valid` is high and clears both permission flags. `cpu_rdata` reads 0xFFFF there. At most one of `sel_ram`, `sel_rom`, `unmapped` is high, and all three are low when `acc_valid` is low.
- R9: `dev_we` is high only for a valid write to a region with write permission. A valid write to a region without write permission raises `write_denied` for exactly the following cycle.
- R10: `cpu_rdata` returns `ram_rdata` for a RAM region and `rom_rdata` for a ROM region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_we | input | 1 | Overlay control write strobe |
| ovl_val | input | 1 | Overlay value written (1 = ROM at zero) |
| acc_valid | input | 1 | Access in progress this cycle |
| acc_write | input | 1 | Access is a write |
| acc_addr | input | 24 | Byte address of the access |
| ram_rdata | input | 16 | Read data from chip RAM |
| rom_rdata | input | 16 | Read data from boot ROM |
| sel_ram | output | 1 | Access goes to chip RAM |
| sel_rom | output | 1 | Access goes to boot ROM |
| unmapped | output | 1 | Access hits a region with no device |
| perm_rd | output | 1 | Region permits reads |
| perm_wr | output | 1 | Region permits writes |
| dev_offset | output | 19 | Offset within the selected device |
| dev_we | output | 1 | Permitted write enable to the device |
| write_denied | output | 1 | One-cycle flag after a refused write |
| cpu_rdata | output | 16 | Read data returned to the CPU |
| overlay_active | output | 1 | Current overlay state |

## Verification
The properties assume `acc_addr`, `acc_valid`, `acc_write`, `ovl_we` and `ovl_val` are settled, known values at each rising edge. They also assume the RAM and ROM read data change only between edges, so the read-data mux comparisons see a stable source. The bench drives every input shortly after a falling edge and holds it across the next rising edge. It mixes overlay writes of both the same and the opposite value with accesses in the same cycle, so each switch is exercised with an access on both sides of it. Addresses are weighted toward regions 0 to 8 and region 63, where the mapping changes, and also drawn across the whole unmapped middle of the space.

// File: rtl/bod_pkg.sv
package bod_pkg;

   typedef enum logic [1:0] {
      DEV_NONE = 2'd0,
      DEV_RAM  = 2'd1,
      DEV_ROM  = 2'd2
   } dev_e;

   typedef struct packed {
      dev_e dev;
      logic rd;
      logic wr;
   } perm_t;

   localparam perm_t MAP_EMPTY = '{dev: DEV_NONE, rd: 1'b0, wr: 1'b0};
   localparam perm_t MAP_ROM   = '{dev: DEV_ROM,  rd: 1'b1, wr: 1'b0};
   localparam perm_t MAP_RAM   = '{dev: DEV_RAM,  rd: 1'b1, wr: 1'b1};

endpackage

// File: rtl/bod_overlay_ctrl.sv
module bod_overlay_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic ctl_we,
   input  logic ctl_val,
   output logic ovl_q,
   output logic remap,
   output logic remap_val
);

   // a rewrite happens only when the written value differs from the held one
   assign remap     = ctl_we && (ctl_val != ovl_q);
   assign remap_val = ctl_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ovl_q <= 1'b1;
      else if (remap) ovl_q <= ctl_val;
   end

endmodule

// File: rtl/bod_region_table.sv
module bod_region_table
   import bod_pkg::*;
#(
   parameter int REGION_W         = 6,
   parameter int DEV_REGIONS      = 2,
   parameter int RAM_MIRRORS      = 4,
   parameter int ROM_HIGH_REGIONS = 1,
   parameter int HALF_W           = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                remap,
   input  logic                remap_val,
   input  logic [REGION_W-1:0] idx,
   output perm_t               ent,
   output logic [HALF_W-1:0]   sub
);

   localparam int NUM_REGIONS = 1 << REGION_W;
   localparam int RAM_SPAN    = DEV_REGIONS * RAM_MIRRORS;
   localparam int HI_BASE     = NUM_REGIONS - ROM_HIGH_REGIONS;

   perm_t             map_tbl [NUM_REGIONS];
   logic [HALF_W-1:0] sub_tbl [NUM_REGIONS];

   for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
      if (i < DEV_REGIONS) begin : g_boot
         // overlaid window: ROM at reset, swapped either way on a change
         perm_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     q <= MAP_ROM;
            else if (remap) q <= remap_val ? MAP_ROM : MAP_RAM;
         end
         assign map_tbl[i] = q;
         assign sub_tbl[i] = HALF_W'(i % DEV_REGIONS);
      end else if (i < RAM_SPAN) begin : g_mirror
         // mirror copies: filled when the overlay drops, never cleared again
         perm_t q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     q <= MAP_EMPTY;
            else if (remap && !remap_val)   q <= MAP_RAM;
         end
         assign map_tbl[i] = q;
         assign sub_tbl[i] = HALF_W'(i % DEV_REGIONS);
      end else if (i >= HI_BASE) begin : g_rom_hi
         assign map_tbl[i] = MAP_ROM;
         assign sub_tbl[i] = HALF_W'(i - HI_BASE);
      end else begin : g_empty
         assign map_tbl[i] = MAP_EMPTY;
         assign sub_tbl[i] = '0;
      end
   end

   assign ent = map_tbl[idx];
   assign sub = sub_tbl[idx];

endmodule

// File: rtl/bod_access_path.sv
module bod_access_path
   import bod_pkg::*;
#(
   parameter int               OFS_W    = 18,
   parameter int               HALF_W   = 1,
   parameter int               DATA_W   = 16,
   parameter logic [DATA_W-1:0] OPEN_BUS = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    acc_valid,
   input  logic                    acc_write,
   input  logic [OFS_W-1:0]        addr_lo,
   input  perm_t                   ent,
   input  logic [HALF_W-1:0]       sub,
   input  logic [DATA_W-1:0]       ram_rdata,
   input  logic [DATA_W-1:0]       rom_rdata,
   output logic                    sel_ram,
   output logic                    sel_rom,
   output logic                    unmapped,
   output logic                    perm_rd,
   output logic                    perm_wr,
   output logic [OFS_W+HALF_W-1:0] dev_offset,
   output logic                    dev_we,
   output logic                    write_denied,
   output logic [DATA_W-1:0]       cpu_rdata
);

   logic deny_now;

   assign sel_ram    = acc_valid && (ent.dev == DEV_RAM);
   assign sel_rom    = acc_valid && (ent.dev == DEV_ROM);
   assign unmapped   = acc_valid && (ent.dev == DEV_NONE);
   assign perm_rd    = ent.rd;
   assign perm_wr    = ent.wr;
   assign dev_offset = {sub, addr_lo};
   assign dev_we     = acc_valid && acc_write && ent.wr;
   assign deny_now   = acc_valid && acc_write && !ent.wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) write_denied <= 1'b0;
      else        write_denied <= deny_now;
   end

   always_comb begin
      unique case (ent.dev)
         DEV_RAM: cpu_rdata = ram_rdata;
         DEV_ROM: cpu_rdata = rom_rdata;
         default: cpu_rdata = OPEN_BUS;
      endcase
   end

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
   import bod_pkg::*;
#(
   parameter int               ADDR_W           = 24,
   parameter int               REGION_W         = 6,
   parameter int               DATA_W           = 16,
   parameter int               DEV_REGIONS      = 2,
   parameter int               RAM_MIRRORS      = 4,
   parameter int               ROM_HIGH_REGIONS = 1,
   parameter logic [DATA_W-1:0] OPEN_BUS        = '1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ovl_we,
   input  logic                          ovl_val,
   input  logic                          acc_valid,
   input  logic                          acc_write,
   input  logic [ADDR_W-1:0]             acc_addr,
   input  logic [DATA_W-1:0]             ram_rdata,
   input  logic [DATA_W-1:0]             rom_rdata,
   output logic                          sel_ram,
   output logic                          sel_rom,
   output logic                          unmapped,
   output logic                          perm_rd,
   output logic                          perm_wr,
   output logic [ADDR_W-REGION_W:0]      dev_offset,
   output logic                          dev_we,
   output logic                          write_denied,
   output logic [DATA_W-1:0]             cpu_rdata,
   output logic                          overlay_active
);

   localparam int NUM_REGIONS = 1 << REGION_W;
   localparam int OFS_W       = ADDR_W - REGION_W;
   localparam int HALF_W      = $clog2(DEV_REGIONS);
   localparam int RAM_SPAN    = DEV_REGIONS * RAM_MIRRORS;

   if (ADDR_W <= REGION_W) begin : g_bad_addr
      $error("address must be wider than the region index");
   end
   if (DEV_REGIONS != 2) begin : g_bad_dev
      $error("device span must be two regions to fit a one-bit upper offset");
   end
   if (ROM_HIGH_REGIONS < 1 || ROM_HIGH_REGIONS > DEV_REGIONS) begin : g_bad_hi
      $error("high ROM window must be within one device");
   end
   if (RAM_SPAN + ROM_HIGH_REGIONS > NUM_REGIONS) begin : g_bad_span
      $error("mirrors and high ROM overlap");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("data width must be positive");
   end

   logic              remap;
   logic              remap_val;
   perm_t             ent;
   logic [HALF_W-1:0] sub;

   bod_overlay_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_we    (ovl_we),
      .ctl_val   (ovl_val),
      .ovl_q     (overlay_active),
      .remap     (remap),
      .remap_val (remap_val)
   );

   bod_region_table #(
      .REGION_W         (REGION_W),
      .DEV_REGIONS      (DEV_REGIONS),
      .RAM_MIRRORS      (RAM_MIRRORS),
      .ROM_HIGH_REGIONS (ROM_HIGH_REGIONS),
      .HALF_W           (HALF_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .remap     (remap),
      .remap_val (remap_val),
      .idx       (acc_addr[ADDR_W-1 -: REGION_W]),
      .ent       (ent),
      .sub       (sub)
   );

   bod_access_path #(
      .OFS_W    (OFS_W),
      .HALF_W   (HALF_W),
      .DATA_W   (DATA_W),
      .OPEN_BUS (OPEN_BUS)
   ) u_path (
      .clk          (clk),
      .rst_n        (rst_n),
      .acc_valid    (acc_valid),
      .acc_write    (acc_write),
      .addr_lo      (acc_addr[OFS_W-1:0]),
      .ent          (ent),
      .sub          (sub),
      .ram_rdata    (ram_rdata),
      .rom_rdata    (rom_rdata),
      .sel_ram      (sel_ram),
      .sel_rom      (sel_rom),
      .unmapped     (unmapped),
      .perm_rd      (perm_rd),
      .perm_wr      (perm_wr),
      .dev_offset   (dev_offset),
      .dev_we       (dev_we),
      .write_denied (write_denied),
      .cpu_rdata    (cpu_rdata)
   );

endmodule

// File: rtl/bod_checker.sv
module bod_checker #(
   parameter int               ADDR_W      = 24,
   parameter int               REGION_W    = 6,
   parameter int               DATA_W      = 16,
   parameter int               DEV_REGIONS = 2,
   parameter int               RAM_MIRRORS = 4,
   parameter logic [DATA_W-1:0] OPEN_BUS   = '1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     ovl_we,
   input logic                     ovl_val,
   input logic                     acc_valid,
   input logic                     acc_write,
   input logic [ADDR_W-1:0]        acc_addr,
   input logic [DATA_W-1:0]        ram_rdata,
   input logic [DATA_W-1:0]        rom_rdata,
   input logic                     sel_ram,
   input logic                     sel_rom,
   input logic                     unmapped,
   input logic                     perm_rd,
   input logic                     perm_wr,
   input logic [ADDR_W-REGION_W:0] dev_offset,
   input logic                     dev_we,
   input logic                     write_denied,
   input logic [DATA_W-1:0]        cpu_rdata,
   input logic                     overlay_active
);

   localparam int OFS_W = ADDR_W - REGION_W;
   localparam logic [REGION_W-1:0] TOP_IDX  = '1;
   localparam logic [REGION_W-1:0] SPAN_IDX = REGION_W'(DEV_REGIONS * RAM_MIRRORS);
   localparam logic [REGION_W-1:0] BOOT_IDX = REGION_W'(DEV_REGIONS);

   logic [REGION_W-1:0] ridx;
   assign ridx = acc_addr[ADDR_W-1 -: REGION_W];

   // R1: low offset bits follow the address on any mapped access
   a_r1_offset_low: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_ram || sel_rom) |-> dev_offset[OFS_W-1:0] == acc_addr[OFS_W-1:0]);

   // R2: overlaid window is read-only ROM
   a_r2_boot_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && overlay_active && ridx < BOOT_IDX) |-> (sel_rom && perm_rd && !perm_wr));

   // R3: top region is ROM in every state, first half of the device
   a_r3_top_rom: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && ridx == TOP_IDX) |-> (sel_rom && !perm_wr && !dev_offset[OFS_W]));

   // R4: RAM mirrors while the overlay is off
   a_r4_ram_mirror: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !overlay_active && ridx < SPAN_IDX)
         |-> (sel_ram && perm_wr && dev_offset == acc_addr[OFS_W:0]));

   // R5: a differing write lands one cycle later; no write holds the state
   a_r5_switch: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_we && ovl_val != overlay_active) |=> (overlay_active == $past(ovl_val)));
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_we |=> $stable(overlay_active));

   // R6: writing the present value changes nothing
   a_r6_same_value: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_we && ovl_val == overlay_active) |=> $stable(overlay_active));

   // R8: device selects exclusive, open bus on unmapped reads
   a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_ram, sel_rom, unmapped}));
   a_r8_open_bus: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped |-> (cpu_rdata == OPEN_BUS && !perm_rd && !perm_wr));

   // R9: write enable only with permission, denial flagged next cycle
   a_r9_we_perm: assert property (@(posedge clk) disable iff (!rst_n)
      dev_we |-> (acc_valid && acc_write && perm_wr));
   a_r9_deny_next: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !perm_wr) |=> write_denied);
   a_r9_deny_cause: assert property (@(posedge clk) disable iff (!rst_n)
      write_denied |-> $past(acc_valid && acc_write && !perm_wr));

   // R10: read data from the selected device
   a_r10_ram_data: assert property (@(posedge clk) disable iff (!rst_n)
      sel_ram |-> cpu_rdata == ram_rdata);
   a_r10_rom_data: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rom |-> cpu_rdata == rom_rdata);

endmodule

bind boot_overlay_decoder bod_checker #(
   .ADDR_W      (ADDR_W),
   .REGION_W    (REGION_W),
   .DATA_W      (DATA_W),
   .DEV_REGIONS (DEV_REGIONS),
   .RAM_MIRRORS (RAM_MIRRORS),
   .OPEN_BUS    (OPEN_BUS)
) u_chk (.*);

// File: tb/boot_overlay_decoder_test.sv
`timescale 1ns/1ps
module boot_overlay_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ovl_we = 1'b0, ovl_val = 1'b0;
   logic        acc_valid = 1'b0, acc_write = 1'b0;
   logic [23:0] acc_addr = '0;
   logic [15:0] ram_rdata = '0, rom_rdata = '0;
   logic        sel_ram, sel_rom, unmapped, perm_rd, perm_wr, dev_we, write_denied, overlay_active;
   logic [18:0] dev_offset;
   logic [15:0] cpu_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   boot_overlay_decoder uut (
      .clk(clk), .rst_n(rst_n), .ovl_we(ovl_we), .ovl_val(ovl_val),
      .acc_valid(acc_valid), .acc_write(acc_write), .acc_addr(acc_addr),
      .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
      .sel_ram(sel_ram), .sel_rom(sel_rom), .unmapped(unmapped),
      .perm_rd(perm_rd), .perm_wr(perm_wr), .dev_offset(dev_offset),
      .dev_we(dev_we), .write_denied(write_denied), .cpu_rdata(cpu_rdata),
      .overlay_active(overlay_active)
   );

   // reference model: device 0 none, 1 RAM, 2 ROM
   int m_dev [64];
   bit m_rd [64];
   bit m_wr [64];
   int m_sub [64];
   bit m_ovl;
   bit m_wd;
   bit same_write;

   task automatic model_reset();
      for (int i = 0; i < 64; i++) begin
         m_dev[i] = 0; m_rd[i] = 0; m_wr[i] = 0; m_sub[i] = 0;
      end
      for (int i = 0; i < 2; i++) begin
         m_dev[i] = 2; m_rd[i] = 1; m_sub[i] = i;
      end
      m_dev[63] = 2; m_rd[63] = 1;
      m_ovl = 1; m_wd = 0; same_write = 0;
   endtask

   task automatic chk(string tag, string what, longint act, longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   function automatic string area_tag(int r);
      if (r == 63) return "R3";
      if (r < 2)   return m_ovl ? "R2" : "R4";
      if (r < 8)   return m_ovl ? "R7" : "R4";
      return "R8";
   endfunction

   task automatic compare();
      int r = int'(acc_addr[23:18]);
      string t = area_tag(r);
      chk(t, "sel_ram", sel_ram, acc_valid && m_dev[r] == 1);
      chk(t, "sel_rom", sel_rom, acc_valid && m_dev[r] == 2);
      chk("R8", "unmapped", unmapped, acc_valid && m_dev[r] == 0);
      chk(t, "perm_rd", perm_rd, m_rd[r]);
      chk(t, "perm_wr", perm_wr, m_wr[r]);
      if (m_dev[r] != 0)
         chk("R1", "dev_offset", dev_offset, m_sub[r] * 262144 + int'(acc_addr[17:0]));
      chk("R9", "dev_we", dev_we, acc_valid && acc_write && m_wr[r]);
      chk("R9", "write_denied", write_denied, m_wd);
      chk("R10", "cpu_rdata", cpu_rdata,
          m_dev[r] == 1 ? ram_rdata : (m_dev[r] == 2 ? rom_rdata : 16'hFFFF));
      chk(same_write ? "R6" : "R5", "overlay_active", overlay_active, m_ovl);
   endtask

   task automatic step(bit v, bit w, int unsigned a, bit owe, bit oval);
      int r;
      @(negedge clk);
      acc_valid = v; acc_write = w; acc_addr = 24'(a);
      ovl_we = owe; ovl_val = oval;
      ram_rdata = 16'($urandom); rom_rdata = 16'($urandom);
      #1;
      compare();
      @(posedge clk);
      r = int'(acc_addr[23:18]);
      m_wd = v && w && !m_wr[r];
      same_write = owe && (oval == m_ovl);
      if (owe && oval != m_ovl) begin
         m_ovl = oval;
         if (oval) begin
            for (int i = 0; i < 2; i++) begin
               m_dev[i] = 2; m_rd[i] = 1; m_wr[i] = 0;
            end
         end else begin
            for (int i = 0; i < 8; i++) begin
               m_dev[i] = 1; m_rd[i] = 1; m_wr[i] = 1; m_sub[i] = i % 2;
            end
         end
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: reset state
      chk("R2", "overlay_active after reset", overlay_active, 1);
      chk("R2", "write_denied after reset", write_denied, 0);

      // R2 / R3 / R8 / R9 with overlay on
      step(1, 0, 24'h000010, 0, 0);
      step(1, 0, 24'h07FFFE, 0, 0);
      step(1, 0, 24'h0C0000, 0, 0);
      step(1, 0, 24'hFC1234, 0, 0);
      step(1, 1, 24'h000000, 0, 0);   // denied write, flag next cycle
      step(1, 1, 24'h500000, 0, 0);   // denied to unmapped, back to back
      step(0, 0, 24'h000000, 0, 0);
      // R6: rewrite same value with an access
      step(1, 0, 24'h040000, 1, 1);
      step(1, 0, 24'h040000, 0, 0);
      // R5: switch off, same-cycle access still sees ROM
      step(1, 1, 24'h000020, 1, 0);
      step(1, 1, 24'h000020, 0, 0);
      // R4: mirrors start at offset zero
      step(1, 0, 24'h040004, 0, 0);
      step(1, 0, 24'h0C0004, 0, 0);
      step(1, 1, 24'h1C0004, 0, 0);
      step(1, 0, 24'h200000, 0, 0);
      step(1, 1, 24'hFFFFFE, 0, 0);
      // R7: back on, mirrors above the boot window remain RAM
      step(1, 0, 24'h100000, 1, 1);
      step(1, 0, 24'h000000, 0, 0);
      step(1, 1, 24'h080000, 0, 0);
      step(1, 1, 24'h1FFFFE, 0, 0);

      for (int n = 0; n < 4000; n++) begin
         int unsigned pick = $urandom % 8;
         int unsigned reg_i;
         if (pick < 5)       reg_i = $urandom % 9;
         else if (pick == 5) reg_i = 63;
         else                reg_i = $urandom % 64;
         step(bit'($urandom % 4 != 0), bit'($urandom % 2),
              (reg_i << 18) | ($urandom & 32'h3FFFF),
              bit'($urandom % 12 == 0), bit'($urandom % 2));
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule